// File: doc/BRIEF.md
# Four-Plane Write Datapath

This block sits between the CPU data bus and a display memory that is split into four 8-bit bit-planes. For every CPU write it computes the byte to store in each plane. It can rotate the CPU byte, replace it per plane with a constant colour, combine it with the previously read memory contents, and mask individual bit positions so that they keep their old contents. Four write modes choose how these steps combine.

A bank of four 8-bit read latches keeps the four plane bytes from the most recent memory read. Those latches feed the logic operations, the per-bit masking and the plane-to-plane copy mode. The write path itself is purely combinational. The latches are the only state and load on a read strobe. A plane write enable is produced for each plane from an external plane-select mask, qualified by a write request. Address generation, the register file and memory timing live outside this block.

Top module: `planar_write_path`

## Requirements
- R1: After synchronous reset all four read latches hold 0x00.
- R2: When `rd_strobe` is 1 at a clock edge, the latches take `rd_planes` (plane n from bits 8n+7..8n). When it is 0 they keep their value.
- R3: In write mode 0 (`wr_mode`=0) the CPU byte is rotated right by `rot_count` (0 to 7) positions.
- R4: In write mode 0 a plane whose `sr_enable` bit n is 1 uses 0xFF if `sr_value` bit n is 1, or 0x00 if it is 0, in place of the rotated CPU byte.
- R5: In write modes 0 and 2 the source byte is combined with that plane's latch according to `logic_fn`: 0 passes the source, 1 ANDs, 2 ORs, 3 XORs.
- R6: In write mode 1 each plane receives its latch byte unchanged.
- R7: In write mode 2, CPU bit n (n = 0 to 3) is copied into all eight bits of plane n's source byte.
- R8: In write mode 3 the rotated CPU byte is ANDed with `bit_mask`. Where the result is 1 a bit takes the plane's `sr_value` bit, and where it is 0 it takes the latch bit.
- R9: In write modes 0 and 2 a `bit_mask` bit of 1 selects the computed bit and a 0 keeps the latch bit.
- R10: `plane_we` equals `map_mask` while `wr_req` is 1 and is 0 otherwise.
- R11: In write mode 3, `logic_fn` and `sr_enable` have no effect on `plane_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Load the latches from `rd_planes` |
| rd_planes | input | 32 | Bytes read from the four planes, plane n in bits 8n+7..8n |
| wr_data | input | 8 | CPU write byte |
| wr_mode | input | 2 | Write mode 0..3 |
| sr_value | input | 4 | Per-plane constant colour bit |
| sr_enable | input | 4 | Per-plane colour substitution enable (mode 0) |
| rot_count | input | 3 | Right rotate amount |
| logic_fn | input | 2 | 0 pass, 1 AND, 2 OR, 3 XOR with the latch |
| bit_mask | input | 8 | Per-bit write select |
| map_mask | input | 4 | Plane select for the write |
| wr_req | input | 1 | Write request qualifying the enables |
| plane_data | output | 32 | Data for the four planes, plane n in bits 8n+7..8n |
| plane_we | output | 4 | Per-plane write enable |

## Verification
On every cycle the assertions check the latch load and hold, that mode 1 copies the latches, that masked-off bits keep the latch value in modes 0, 2 and 3, and that the write enables stay within the plane-select mask and drop when no write is requested. Rotation direction, colour substitution, the four logic functions, the bit-to-plane spread of mode 2 and the pattern fill of mode 3 show up only when the bench's reference model compares full plane bytes under chosen and random inputs. The reset value of the latches is also shown only by the bench.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    localparam int PLANES  = 4;
    localparam int PLANE_W = 8;
    localparam int ROT_W   = $clog2(PLANE_W);
    localparam int BUS_W   = PLANES * PLANE_W;

    typedef logic [PLANE_W-1:0] pbyte_t;

    typedef enum logic [1:0] {
        WM_SHIFT   = 2'd0,
        WM_COPY    = 2'd1,
        WM_COLOR   = 2'd2,
        WM_PATTERN = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        LF_PASS = 2'd0,
        LF_AND  = 2'd1,
        LF_OR   = 2'd2,
        LF_XOR  = 2'd3
    } lfn_e;

    typedef struct packed {
        wmode_e mode;
        lfn_e   fn;
        pbyte_t mask;
    } wcfg_t;

    typedef struct packed {
        logic   sr_bit;
        logic   en_bit;
        logic   cpu_bit;
        pbyte_t latch;
    } lane_in_t;

    function automatic pbyte_t rot_right(input pbyte_t d, input logic [ROT_W-1:0] n);
        logic [2*PLANE_W-1:0] t;
        t = {d, d} >> n;
        return t[PLANE_W-1:0];
    endfunction

    function automatic pbyte_t fill(input logic b);
        return {PLANE_W{b}};
    endfunction

    function automatic pbyte_t logic_op(input lfn_e f, input pbyte_t a, input pbyte_t l);
        pbyte_t r;
        case (f)
            LF_AND:  r = a & l;
            LF_OR:   r = a | l;
            LF_XOR:  r = a ^ l;
            default: r = a;
        endcase
        return r;
    endfunction

    function automatic pbyte_t merge(input pbyte_t sel, input pbyte_t a, input pbyte_t b);
        return (a & sel) | (b & ~sel);
    endfunction

endpackage

// File: rtl/pwd_latch_bank.sv
module pwd_latch_bank
    import pwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] q
);

    for (genvar p = 0; p < PLANES; p++) begin : g_lat
        pbyte_t r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (load)
                r <= din[p*PLANE_W +: PLANE_W];
        end
        assign q[p*PLANE_W +: PLANE_W] = r;
    end

endmodule

// File: rtl/pwd_rotator.sv
module pwd_rotator
    import pwd_pkg::*;
(
    input  pbyte_t           din,
    input  logic [ROT_W-1:0] amount,
    output pbyte_t           dout
);

    always_comb dout = rot_right(din, amount);

endmodule

// File: rtl/pwd_lane.sv
module pwd_lane
    import pwd_pkg::*;
(
    input  wcfg_t    cfg,
    input  pbyte_t   rot_data,
    input  lane_in_t lin,
    output pbyte_t   dout
);

    pbyte_t src;
    pbyte_t alu;
    pbyte_t pat_sel;

    always_comb begin
        src     = rot_data;
        alu     = '0;
        pat_sel = rot_data & cfg.mask;
        dout    = lin.latch;
        case (cfg.mode)
            WM_SHIFT: begin
                src  = lin.en_bit ? fill(lin.sr_bit) : rot_data;
                alu  = logic_op(cfg.fn, src, lin.latch);
                dout = merge(cfg.mask, alu, lin.latch);
            end
            WM_COPY: begin
                dout = lin.latch;
            end
            WM_COLOR: begin
                src  = fill(lin.cpu_bit);
                alu  = logic_op(cfg.fn, src, lin.latch);
                dout = merge(cfg.mask, alu, lin.latch);
            end
            WM_PATTERN: begin
                dout = merge(pat_sel, fill(lin.sr_bit), lin.latch);
            end
            default: dout = lin.latch;
        endcase
    end

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
    import pwd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_strobe,
    input  logic [PLANES*PLANE_W-1:0] rd_planes,
    input  logic [PLANE_W-1:0]        wr_data,
    input  logic [1:0]                wr_mode,
    input  logic [PLANES-1:0]         sr_value,
    input  logic [PLANES-1:0]         sr_enable,
    input  logic [ROT_W-1:0]          rot_count,
    input  logic [1:0]                logic_fn,
    input  logic [PLANE_W-1:0]        bit_mask,
    input  logic [PLANES-1:0]         map_mask,
    input  logic                      wr_req,
    output logic [PLANES*PLANE_W-1:0] plane_data,
    output logic [PLANES-1:0]         plane_we
);

    logic [BUS_W-1:0] latch_q;
    pbyte_t           rot_data;
    wcfg_t            cfg;

    pwd_latch_bank u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (rd_strobe),
        .din  (rd_planes),
        .q    (latch_q)
    );

    pwd_rotator u_rot (
        .din    (wr_data),
        .amount (rot_count),
        .dout   (rot_data)
    );

    always_comb begin
        cfg.mode = wmode_e'(wr_mode);
        cfg.fn   = lfn_e'(logic_fn);
        cfg.mask = bit_mask;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        lane_in_t lin;
        pbyte_t   lout;
        always_comb begin
            lin.sr_bit  = sr_value[p];
            lin.en_bit  = sr_enable[p];
            lin.cpu_bit = wr_data[p];
            lin.latch   = latch_q[p*PLANE_W +: PLANE_W];
        end
        pwd_lane u_lane (
            .cfg      (cfg),
            .rot_data (rot_data),
            .lin      (lin),
            .dout     (lout)
        );
        assign plane_data[p*PLANE_W +: PLANE_W] = lout;
    end

    always_comb plane_we = wr_req ? map_mask : '0;

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker
    import pwd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rd_strobe,
    input logic [BUS_W-1:0] rd_planes,
    input logic [BUS_W-1:0] latch_q,
    input logic [1:0]       wr_mode,
    input logic [PLANE_W-1:0] bit_mask,
    input logic             wr_req,
    input logic [PLANES-1:0] map_mask,
    input logic [BUS_W-1:0] plane_data,
    input logic [PLANES-1:0] plane_we
);

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> latch_q == $past(rd_planes)); // R2

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(latch_q)); // R2

    AST_COPY_MODE: assert property (@(posedge clk) disable iff (rst)
        wr_mode == 2'd1 |-> plane_data == latch_q); // R6

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_mode == 2'd0 || wr_mode == 2'd2) |->
            ((plane_data ^ latch_q) & {PLANES{~bit_mask}}) == '0); // R9

    AST_PATTERN_KEEP: assert property (@(posedge clk) disable iff (rst)
        wr_mode == 2'd3 |->
            ((plane_data ^ latch_q) & {PLANES{~bit_mask}}) == '0); // R8

    AST_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_req |-> plane_we == '0); // R10

    AST_WE_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (plane_we & ~map_mask) == '0); // R10

endmodule

bind planar_write_path pwd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_strobe  (rd_strobe),
    .rd_planes  (rd_planes),
    .latch_q    (latch_q),
    .wr_mode    (wr_mode),
    .bit_mask   (bit_mask),
    .wr_req     (wr_req),
    .map_mask   (map_mask),
    .plane_data (plane_data),
    .plane_we   (plane_we)
);

// File: tb/planar_write_path_tb.sv
module planar_write_path_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_planes = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  wr_mode = '0;
    logic [3:0]  sr_value = '0;
    logic [3:0]  sr_enable = '0;
    logic [2:0]  rot_count = '0;
    logic [1:0]  logic_fn = '0;
    logic [7:0]  bit_mask = 8'hFF;
    logic [3:0]  map_mask = '0;
    logic        wr_req = 1'b0;
    logic [31:0] plane_data;
    logic [3:0]  plane_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mlat;

    always #(CLK_PERIOD/2) clk = ~clk;

    planar_write_path u_dut (
        .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_planes(rd_planes),
        .wr_data(wr_data), .wr_mode(wr_mode), .sr_value(sr_value),
        .sr_enable(sr_enable), .rot_count(rot_count), .logic_fn(logic_fn),
        .bit_mask(bit_mask), .map_mask(map_mask), .wr_req(wr_req),
        .plane_data(plane_data), .plane_we(plane_we)
    );

    // behavioural latch model
    always @(posedge clk) begin
        if (rst) mlat <= '0;
        else if (rd_strobe) mlat <= rd_planes;
    end

    function automatic logic [31:0] model_data(input logic [31:0] lat);
        logic [31:0] res;
        res = '0;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 8; b++) begin
                logic l, m, r, s, a, o;
                l = lat[p*8+b];
                m = bit_mask[b];
                r = wr_data[(b + int'(rot_count)) % 8];
                s = (wr_mode == 2'd0) ? (sr_enable[p] ? sr_value[p] : r) : wr_data[p];
                case (logic_fn)
                    2'd1: a = s & l;
                    2'd2: a = s | l;
                    2'd3: a = s ^ l;
                    default: a = s;
                endcase
                case (wr_mode)
                    2'd1: o = l;
                    2'd3: o = (r & m) ? sr_value[p] : l;
                    default: o = m ? a : l;
                endcase
                res[p*8+b] = o;
            end
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            case (wr_mode)
                2'd0: check("R3 R4 R5 R9 mode0", plane_data, model_data(mlat));
                2'd1: check("R6 mode1", plane_data, model_data(mlat));
                2'd2: check("R7 R5 R9 mode2", plane_data, model_data(mlat));
                default: check("R8 mode3", plane_data, model_data(mlat));
            endcase
            check("R10 enables", {28'd0, plane_we}, {28'd0, wr_req ? map_mask : 4'd0});
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [31:0] v);
        rd_planes = v;
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: latches cleared, seen through copy mode
        wr_mode = 2'd1; wr_req = 1'b1; map_mask = 4'hF;
        @(negedge clk);
        check("R1 reset latches", plane_data, 32'h0);

        // R2: load then hold
        tick();
        load(32'h11223344);
        rd_planes = 32'hDEADBEEF;
        tick();
        @(negedge clk);
        check("R2 latch hold", plane_data, 32'h11223344);
        check("R6 copy mode", plane_data, 32'h11223344);

        // R3: rotate right
        tick();
        wr_mode = 2'd0; logic_fn = 2'd0; bit_mask = 8'hFF; sr_enable = 4'h0;
        wr_data = 8'h01; rot_count = 3'd3;
        @(negedge clk);
        check("R3 rotate", plane_data, 32'h20202020);

        // R4: per-plane colour substitution
        tick();
        rot_count = 3'd0; wr_data = 8'hAA; sr_enable = 4'b0101; sr_value = 4'b0001;
        @(negedge clk);
        check("R4 set/reset", plane_data, 32'hAA00AAFF);

        // R5: logic functions against latches of 0x0F
        tick();
        load(32'h0F0F0F0F);
        sr_enable = 4'h0; wr_data = 8'h3C;
        logic_fn = 2'd1;
        @(negedge clk);
        check("R5 AND", plane_data, 32'h0C0C0C0C);
        tick();
        logic_fn = 2'd2;
        @(negedge clk);
        check("R5 OR", plane_data, 32'h3F3F3F3F);
        tick();
        logic_fn = 2'd3;
        @(negedge clk);
        check("R5 XOR", plane_data, 32'h33333333);

        // R9: bit mask keeps latch bits
        tick();
        logic_fn = 2'd0; wr_data = 8'hF0; bit_mask = 8'hC3;
        @(negedge clk);
        check("R9 bit mask", plane_data, 32'hCCCCCCCC);

        // R7: colour spread in mode 2
        tick();
        wr_mode = 2'd2; bit_mask = 8'hFF; wr_data = 8'hF5;
        @(negedge clk);
        check("R7 mode2 spread", plane_data, 32'h00FF00FF);

        // R8: pattern fill in mode 3
        tick();
        wr_mode = 2'd3; sr_value = 4'b0011; wr_data = 8'hF0; bit_mask = 8'h3C;
        @(negedge clk);
        check("R8 pattern", plane_data, 32'h0F0F3F3F);

        // R11: logic function and substitution enable ignored in mode 3
        tick();
        logic_fn = 2'd3; sr_enable = 4'hF;
        @(negedge clk);
        check("R11 mode3 ignores fn/enable", plane_data, 32'h0F0F3F3F);

        // R10: enables
        tick();
        wr_req = 1'b0; map_mask = 4'b1010;
        @(negedge clk);
        check("R10 no request", {28'd0, plane_we}, 32'h0);
        tick();
        wr_req = 1'b1;
        @(negedge clk);
        check("R10 map mask", {28'd0, plane_we}, 32'hA);

        // random phase, compared every cycle by the model
        for (int i = 0; i < 400; i++) begin
            tick();
            rd_strobe = ($urandom_range(0, 3) == 0);
            rd_planes = $urandom;
            wr_data   = 8'($urandom);
            wr_mode   = 2'($urandom);
            sr_value  = 4'($urandom);
            sr_enable = 4'($urandom);
            rot_count = 3'($urandom);
            logic_fn  = 2'($urandom);
            bit_mask  = 8'($urandom);
            map_mask  = 4'($urandom);
            wr_req    = 1'($urandom);
        end
        @(negedge clk);
        finish_run();
    end

endmodule